// File: doc/BRIEF.md
# Single-Lane Floating-Point Compare Predicate Unit

This block compares two single-precision IEEE-754 values for one lane of a vector compare datapath. It sorts the pair into one of four relations: less, equal, greater or unordered. It then looks up the relation in a 5-bit predicate code to produce a one-bit verdict. It also works out the two exception flags that the compare can raise: invalid-operation and denormal-operand.

The unit is purely combinational. A surrounding vector unit places one copy per lane. That unit supplies the operands and the predicate code, and it handles lane masking, result widening and exception trapping itself. The verdict and the flags are valid in the same cycle that the inputs are presented.

Top module: `fcmp_lane`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. If either operand is a NaN, the relation is unordered. Under that relation every predicate whose unordered entry is false returns 0.
- R2: Positive zero and negative zero compare as equal under every predicate.
- R3: Ordered operands, including infinities, are ranked by sign first and then by magnitude. When both operands are negative, the magnitude ranking is reversed.
- R4: The low four predicate bits set the verdict for the four relations (bit0 less, bit1 equal, bit2 greater, bit3 unordered).
  - Bits[1:0] pick a base set: 00 gives equal, 01 gives less, 10 gives less-or-equal, and 11 gives unordered only.
  - Bit 2 complements the whole set.
  - Bit 3 then complements the unordered entry.
  - Bit 4 has no effect on the verdict.
- R5: Codes 0Bh and 1Bh return 0, and codes 0Fh and 1Fh return 1, whatever the operands.
- R6: A quiet NaN (fraction MSB, bit 22, set) raises the invalid flag only under signaling predicates. With bit 4 clear, the signaling codes are those whose low nibble is 1, 2, 5, 6, 9, Ah, Dh or Eh. Setting bit 4 swaps the signaling and non-signaling sets.
- R7: A signaling NaN (fraction bit 22 clear) raises the invalid flag under every predicate.
- R8: The invalid flag is never raised when neither operand is a NaN.
- R9: The denormal flag is raised when either operand has a zero exponent and a nonzero fraction. This holds under every predicate and alongside any other outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (single precision) |
| b_i | input | 32 | Second operand (single precision) |
| pred_i | input | 5 | Predicate code |
| hit_o | output | 1 | Verdict of the predicate for this pair |
| inv_o | output | 1 | Invalid-operation flag |
| den_o | output | 1 | Denormal-operand flag |

## Verification
The invalid flag and the denormal flag can be raised by the same operand pair. This happens when one operand is a NaN and the other is a denormal. In that case the verdict must also follow the unordered column. The bench provokes the overlap directly by pairing a signaling NaN with a denormal, and a quiet NaN with a negative denormal, under both signaling and quiet predicate codes. The random pool draws NaNs and denormals often enough for this pairing to recur. Each output is judged separately against the bench's own relation key, truth table and signaling set.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int PRED_W = 5;

  // relation index: bit position in a predicate truth set
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic qnan;
    logic zero;
    logic denorm;
  } opclass_t;

  // truth set {UN,GT,EQ,LT} from the low predicate nibble
  function automatic logic [3:0] pred_truth(input logic [3:0] code);
    logic [3:0] t;
    case (code[1:0])
      2'b00:   t = 4'b0010;
      2'b01:   t = 4'b0001;
      2'b10:   t = 4'b0011;
      default: t = 4'b1000;
    endcase
    if (code[2]) t = ~t;
    if (code[3]) t[REL_UN] = ~t[REL_UN];
    return t;
  endfunction

  // whether a quiet NaN signals invalid under this code
  function automatic logic pred_signals(input logic [PRED_W-1:0] code);
    return (code[0] ^ code[1]) ^ code[4];
  endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output opclass_t              cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones, exp_zero, frac_nz;

  assign exp_f    = op_i[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f   = op_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls_o.nan    = exp_ones & frac_nz;
    cls_o.qnan   = exp_ones & frac_nz & frac_f[FRAC_W-1];
    cls_o.snan   = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls_o.zero   = exp_zero & ~frac_nz;
    cls_o.denorm = exp_zero & frac_nz;
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  logic                  a_nan_i,
  input  logic                  b_nan_i,
  input  logic                  a_zero_i,
  input  logic                  b_zero_i,
  output rel_e                  rel_o
);
  localparam int MAG_W = EXP_W + FRAC_W;

  // sign-magnitude ranking of two non-NaN, not-both-zero values
  function automatic rel_e rank(input logic [MAG_W:0] x, input logic [MAG_W:0] y);
    logic x_lt_y;
    if (x == y) return REL_EQ;
    if (x[MAG_W] != y[MAG_W]) return x[MAG_W] ? REL_LT : REL_GT;
    x_lt_y = x[MAG_W-1:0] < y[MAG_W-1:0];
    if (x[MAG_W]) x_lt_y = ~x_lt_y;
    return x_lt_y ? REL_LT : REL_GT;
  endfunction

  always_comb begin
    if (a_nan_i || b_nan_i)        rel_o = REL_UN;
    else if (a_zero_i && b_zero_i) rel_o = REL_EQ;
    else                           rel_o = rank(a_i, b_i);
  end
endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred
  import fcmp_pkg::*;
(
  input  logic [PRED_W-1:0] code_i,
  output logic [3:0]        truth_o,
  output logic              sig_o
);
  assign truth_o = pred_truth(code_i[3:0]);
  assign sig_o   = pred_signals(code_i);
endmodule

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  logic [PRED_W-1:0]     pred_i,
  output logic                  hit_o,
  output logic                  inv_o,
  output logic                  den_o
);
  opclass_t   cls_a, cls_b;
  rel_e       rel;
  logic [3:0] truth;
  logic       sig_q;
  logic       any_snan, any_qnan, any_nan;

  fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.op_i(a_i), .cls_o(cls_a));
  fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.op_i(b_i), .cls_o(cls_b));

  fcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .a_i(a_i), .b_i(b_i),
    .a_nan_i(cls_a.nan), .b_nan_i(cls_b.nan),
    .a_zero_i(cls_a.zero), .b_zero_i(cls_b.zero),
    .rel_o(rel)
  );

  fcmp_pred u_pred (.code_i(pred_i), .truth_o(truth), .sig_o(sig_q));

  assign any_snan = cls_a.snan | cls_b.snan;
  assign any_qnan = cls_a.qnan | cls_b.qnan;
  assign any_nan  = cls_a.nan  | cls_b.nan;

  assign hit_o = truth[rel];
  assign inv_o = any_snan | (any_qnan & sig_q);
  assign den_o = cls_a.denorm | cls_b.denorm;

  always_comb begin
    if (!$isunknown({a_i, b_i, pred_i})) begin
      if (any_nan)
        assert_nan_unordered_R1: assert (rel == REL_UN);
      if (cls_a.zero && cls_b.zero)
        assert_zeros_equal_R2: assert (rel == REL_EQ);
      if (pred_i[3:0] == 4'hB)
        assert_const_false_R5: assert (!hit_o);
      if (pred_i[3:0] == 4'hF)
        assert_const_true_R5: assert (hit_o);
      if (any_snan)
        assert_snan_invalid_R7: assert (inv_o);
      if (!any_nan)
        assert_no_nan_no_invalid_R8: assert (!inv_o);
    end
  end
endmodule

// File: tb/sim_fcmp_lane.sv
module sim_fcmp_lane;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  p;
  logic        hit, inv, den;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fcmp_lane u0 (.a_i(a), .b_i(b), .pred_i(p), .hit_o(hit), .inv_o(inv), .den_o(den));

  function automatic bit m_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit m_snan(input logic [31:0] x);
    return m_nan(x) && !x[22];
  endfunction
  function automatic bit m_den(input logic [31:0] x);
    return (x[30:23] == 0) && (x[22:0] != 0);
  endfunction
  // monotone unsigned key; -0 folded onto +0
  function automatic logic [31:0] m_key(input logic [31:0] x);
    logic [31:0] y;
    y = (x[30:0] == 0) ? 32'h0 : x;
    return y[31] ? ~y : (y | 32'h8000_0000);
  endfunction
  // 0 lt, 1 eq, 2 gt, 3 unordered
  function automatic int m_rel(input logic [31:0] x, input logic [31:0] y);
    if (m_nan(x) || m_nan(y)) return 3;
    if (m_key(x) < m_key(y)) return 0;
    if (m_key(x) > m_key(y)) return 2;
    return 1;
  endfunction
  function automatic logic [3:0] m_table(input logic [3:0] c);
    case (c)
      4'h0: return 4'b0010; 4'h1: return 4'b0001; 4'h2: return 4'b0011; 4'h3: return 4'b1000;
      4'h4: return 4'b1101; 4'h5: return 4'b1110; 4'h6: return 4'b1100; 4'h7: return 4'b0111;
      4'h8: return 4'b1010; 4'h9: return 4'b1001; 4'hA: return 4'b1011; 4'hB: return 4'b0000;
      4'hC: return 4'b0101; 4'hD: return 4'b0110; 4'hE: return 4'b0100; default: return 4'b1111;
    endcase
  endfunction
  function automatic bit m_sig(input logic [4:0] c);
    bit s;
    case (c[3:0])
      4'h1, 4'h2, 4'h5, 4'h6, 4'h9, 4'hA, 4'hD, 4'hE: s = 1'b1;
      default: s = 1'b0;
    endcase
    return s ^ c[4];
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [4:0] c,
                       input string tag);
    logic [3:0] t;
    bit e_hit, e_inv, e_den;
    @(posedge clk);
    #1;
    a = x; b = y; p = c;
    t     = m_table(c[3:0]);
    e_hit = t[m_rel(x, y)];
    e_inv = m_snan(x) || m_snan(y) || ((m_nan(x) || m_nan(y)) && m_sig(c));
    e_den = m_den(x) || m_den(y);
    @(negedge clk);
    vectors++;
    if (hit !== e_hit) begin
      miscompares++;
      $display("FAIL %s hit a=%h b=%h p=%h actual=%b expected=%b", tag, x, y, c, hit, e_hit);
    end
    if (inv !== e_inv) begin
      miscompares++;
      $display("FAIL %s/R6-R7-R8 inv a=%h b=%h p=%h actual=%b expected=%b", tag, x, y, c, inv, e_inv);
    end
    if (den !== e_den) begin
      miscompares++;
      $display("FAIL %s/R9 den a=%h b=%h p=%h actual=%b expected=%b", tag, x, y, c, den, e_den);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 14)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h7F80_0000;  3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000 | ($urandom & 32'h803F_FFFF);
      5: return 32'h7F80_0001 | ($urandom & 32'h801F_FFFF);
      6: return $urandom & 32'h807F_FFFF;
      7: return 32'h3F80_0000;  8: return 32'hBF80_0000;
      9: return 32'h7F7F_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    a = 0; b = 0; p = 0;
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(posedge clk);
    // reset state: zero operands under code 0 give equal
    @(negedge clk);
    vectors++;
    if (hit !== 1'b1 || inv !== 1'b0 || den !== 1'b0) begin
      miscompares++;
      $display("FAIL R2 reset hit/inv/den actual=%b%b%b expected=100", hit, inv, den);
    end
    rst_n = 1'b1;
    apply(32'h0000_0000, 32'h8000_0000, 5'h00, "R2");
    apply(32'h8000_0000, 32'h0000_0000, 5'h01, "R2");
    apply(32'h3F80_0000, 32'h4000_0000, 5'h01, "R3");
    apply(32'hBF80_0000, 32'hC000_0000, 5'h01, "R3");
    apply(32'hC000_0000, 32'hBF80_0000, 5'h0E, "R3");
    apply(32'hFF80_0000, 32'h7F80_0000, 5'h01, "R3");
    apply(32'h7FC0_0000, 32'h3F80_0000, 5'h00, "R1");
    apply(32'h3F80_0000, 32'h7FC0_0000, 5'h03, "R1");
    apply(32'h7FC0_0000, 32'h7FC0_0000, 5'h07, "R1");
    apply(32'h7FC0_0000, 32'h3F80_0000, 5'h01, "R6");
    apply(32'h7FC0_0000, 32'h3F80_0000, 5'h11, "R6");
    apply(32'h7FC0_0000, 32'h3F80_0000, 5'h10, "R6");
    apply(32'h7F80_0001, 32'h3F80_0000, 5'h00, "R7");
    apply(32'h3F80_0000, 32'hFFA0_0000, 5'h1F, "R7");
    apply(32'h3F80_0000, 32'h3F80_0000, 5'h0B, "R5");
    apply(32'h7FC0_0000, 32'h0000_0000, 5'h1B, "R5");
    apply(32'h7FC0_0000, 32'h0000_0000, 5'h0F, "R5");
    apply(32'h4000_0000, 32'h3F80_0000, 5'h14, "R4");
    apply(32'h0000_0001, 32'h3F80_0000, 5'h02, "R9");
    apply(32'h0000_0001, 32'h7F80_0001, 5'h04, "R9");
    apply(32'h8040_0000, 32'h7FC0_0000, 5'h0D, "R9");
    apply(32'h8040_0000, 32'h7FC0_0000, 5'h1D, "R8");
    for (int c = 0; c < 32; c++) begin
      apply(32'h3F80_0000, 32'h4000_0000, c[4:0], "R4");
      apply(32'h3F80_0000, 32'h3F80_0000, c[4:0], "R4");
      apply(32'h4000_0000, 32'h3F80_0000, c[4:0], "R4");
      apply(32'h7FC0_0000, 32'h4000_0000, c[4:0], "R4");
    end
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x, y;
      x = pick();
      y = ($urandom % 5 == 0) ? x : pick();
      apply(x, y, 5'($urandom), "R4");
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule